// File: doc/BRIEF.md
# I2C Receive Data Double Buffer

This block sits between the byte-level serial engine of an I2C controller and the data register that the CPU reads and writes. Received bits are shifted into a receive shift stage. When the engine signals that a frame is complete, the frame moves into a holding buffer and a full flag is raised. If the buffer still holds an unread byte, the new frame stays in the shift stage. The block then raises a hold indication so that the engine stalls. The parked frame moves into the buffer as soon as the CPU reads the data register.

The engine supplies the current direction (receive or transmit) and the frame length of one to eight bits. It also supplies a bit-order select, which decides how frames shorter than a byte are aligned. In the receive direction the select places the valid bits at one end of the byte. In the transmit direction the select sets the end of the CPU-written byte from which the transmit bits are taken. The CPU path works only while the interface-enable input is high.

Top module: `i2c_rx_dbuf`

## Requirements
- R1: After reset, full_o and hold_o are both 0.
- R2: In receive mode (xmit_mode_i=0), a frame_done_i pulse while full_o=0 and hold_o=0 loads the aligned frame into the buffer and sets full_o on the next cycle. rdata_o then shows the frame.
- R3: In receive mode, a frame_done_i pulse while full_o=1 and no enabled read in that cycle leaves the buffer unchanged and sets hold_o on the next cycle. The frame stays in the shift stage.
- R4: An enabled read while hold_o=1 in receive mode moves the parked frame into the buffer. full_o stays 1 and hold_o falls on the next cycle.
- R5: An enabled read while hold_o=0 and no frame completes clears full_o on the next cycle.
- R6: With xmit_mode_i=1, frame_done_i never loads the buffer or sets full_o. Any cycle with xmit_mode_i=1 clears hold_o and discards the parked frame.
- R7: For a received frame of n<8 bits, the first received bit is the most significant valid bit and unused bit positions read 0. With lsb_first_i=0 the valid bits occupy bits n-1..0. With lsb_first_i=1 they occupy bits 7..8-n.
- R8: tx_data_o presents the transmit bits MSB-justified in bits 7..8-n, with the remaining bits 0. With lsb_first_i=0 these are the top n bits of the written byte. With lsb_first_i=1 they are its low n bits.
- R9: While en_i=0, rdata_o reads 0, a read strobe does not change full_o or hold_o, and a write strobe does not change tx_data_o.
- R10: A frame_bits_i value of 0 means an eight-bit frame. Any other value is the frame length in bits.
- R11: A frame that completes in the same cycle as an enabled read of a full buffer (hold_o=0) goes straight into the buffer. full_o stays 1 and hold_o stays 0.
- R12: While hold_o=1, bit_valid_i and frame_done_i are ignored, so the parked frame is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Interface enable; gates CPU data-register access |
| xmit_mode_i | input | 1 | Direction: 0 receive, 1 transmit |
| lsb_first_i | input | 1 | Bit-order select for short frames |
| frame_bits_i | input | 3 | Frame length in bits, 0 means 8 |
| bit_valid_i | input | 1 | A received bit is present on bit_i |
| bit_i | input | 1 | Received serial bit, first bit is the most significant |
| frame_done_i | input | 1 | One-cycle pulse: the current frame is complete |
| hold_o | output | 1 | A frame is parked in the shift stage; the engine must stall |
| rd_i | input | 1 | CPU read strobe of the data register |
| wr_i | input | 1 | CPU write strobe of the data register |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data (0 while en_i=0) |
| full_o | output | 1 | Receive buffer holds an unread byte |
| tx_data_o | output | 8 | MSB-justified transmit bits for the serial engine |

## Verification
The bench sends a full eight-bit frame into an empty buffer, then two back-to-back frames that force the parking path. It also sends a frame whose completion coincides with a CPU read, which shows whether the direct load and the parking path are told apart correctly. Short frames with both bit-order settings are sent on top of a shift stage holding stale ones, so that both the alignment and the masking of unused bits are visible. Disabled accesses, transmit-mode frame pulses and a direction switch while a frame is parked each show whether the buffer, the flags and the transmit byte are left alone or discarded as required.

// File: rtl/i2c_rxdb_pkg.sv
package i2c_rxdb_pkg;

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } xfer_mode_e;

  typedef enum logic {
    ALIGN_RX = 1'b0,
    ALIGN_TX = 1'b1
  } align_kind_e;

endpackage

// File: rtl/frame_align.sv
module frame_align
  import i2c_rxdb_pkg::*;
#(
  parameter int          W    = 8,
  parameter align_kind_e KIND = ALIGN_RX,
  localparam int         CW   = $clog2(W)
) (
  input  logic [W-1:0]  raw_i,
  input  logic [CW-1:0] len_i,
  input  logic          lsb_sel_i,
  output logic [W-1:0]  out_o
);

  logic [CW:0]  n_bits;
  logic [CW:0]  shamt;
  logic [W-1:0] lo_mask;
  logic [W-1:0] hi_mask;

  // zero length encodes a full-width frame
  assign n_bits = (len_i == '0) ? (CW+1)'(W) : {1'b0, len_i};
  assign shamt  = (CW+1)'(W) - n_bits;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      lo_mask[i] = (i < int'(n_bits));
      hi_mask[i] = (i >= W - int'(n_bits));
    end
  end

  generate
    if (KIND == ALIGN_RX) begin : g_rx
      // shift stage fills from the LSB end
      always_comb begin
        if (lsb_sel_i) out_o = (raw_i & lo_mask) << shamt;
        else           out_o = raw_i & lo_mask;
      end
    end else begin : g_tx
      // engine always transmits from the MSB end
      always_comb begin
        if (lsb_sel_i) out_o = (raw_i & lo_mask) << shamt;
        else           out_o = raw_i & hi_mask;
      end
    end
  endgenerate

endmodule

// File: rtl/rx_shift_stage.sv
module rx_shift_stage #(
  parameter  int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_en_i,
  input  logic          bit_i,
  input  logic          park_i,
  input  logic          unpark_i,
  input  logic [CW-1:0] len_i,
  input  logic          ord_i,
  output logic [W-1:0]  sr_o,
  output logic          parked_o,
  output logic [CW-1:0] len_o,
  output logic          ord_o
);

  logic [W-1:0]  sr_q;
  logic          parked_q;
  logic [CW-1:0] len_q;
  logic          ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (shift_en_i) begin
      sr_q <= {sr_q[W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      parked_q <= 1'b0;
      len_q    <= '0;
      ord_q    <= 1'b0;
    end else if (park_i) begin
      parked_q <= 1'b1;
      len_q    <= len_i;
      ord_q    <= ord_i;
    end else if (unpark_i) begin
      parked_q <= 1'b0;
    end
  end

  assign sr_o     = sr_q;
  assign parked_o = parked_q;
  assign len_o    = len_q;
  assign ord_o    = ord_q;

endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         clr_i,
  output logic [W-1:0] dout_o,
  output logic         full_o
);

  logic [W-1:0] data_q;
  logic         full_q;

  // data register has no defined reset value
  always_ff @(posedge clk_i) begin
    if (load_i) data_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     full_q <= 1'b0;
    else if (load_i) full_q <= 1'b1;
    else if (clr_i)  full_q <= 1'b0;
  end

  assign dout_o = data_q;
  assign full_o = full_q;

endmodule

// File: rtl/i2c_rx_dbuf.sv
module i2c_rx_dbuf
  import i2c_rxdb_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              xmit_mode_i,
  input  logic              lsb_first_i,
  input  logic [CNT_W-1:0]  frame_bits_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              frame_done_i,
  output logic              hold_o,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic [DATA_W-1:0] tx_data_o
);

  xfer_mode_e        mode;
  logic              rx_mode;
  logic              rd_ok, wr_ok;
  logic              parked;
  logic              full;
  logic              shift_en, done_rx;
  logic              load_direct, park, unpark, park_clr;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  park_len;
  logic              park_ord;
  logic [DATA_W-1:0] rx_now, rx_parked, buf_din, buf_dout;
  logic [DATA_W-1:0] tx_q;

  assign mode    = xfer_mode_e'(xmit_mode_i);
  assign rx_mode = (mode == MODE_RX);
  assign rd_ok   = rd_i & en_i;
  assign wr_ok   = wr_i & en_i;

  // engine is stalled while a frame is parked
  assign shift_en    = bit_valid_i & rx_mode & ~parked;
  assign done_rx     = frame_done_i & rx_mode & ~parked;
  assign load_direct = done_rx & (~full | rd_ok);
  assign park        = done_rx & full & ~rd_ok;
  assign unpark      = rd_ok & parked & rx_mode;
  assign park_clr    = unpark | ~rx_mode;
  assign buf_din     = load_direct ? rx_now : rx_parked;

  rx_shift_stage #(.W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (bit_i),
    .park_i    (park),
    .unpark_i  (park_clr),
    .len_i     (frame_bits_i),
    .ord_i     (lsb_first_i),
    .sr_o      (sr),
    .parked_o  (parked),
    .len_o     (park_len),
    .ord_o     (park_ord)
  );

  frame_align #(.W(DATA_W), .KIND(ALIGN_RX)) u_align_now (
    .raw_i    (sr),
    .len_i    (frame_bits_i),
    .lsb_sel_i(lsb_first_i),
    .out_o    (rx_now)
  );

  frame_align #(.W(DATA_W), .KIND(ALIGN_RX)) u_align_parked (
    .raw_i    (sr),
    .len_i    (park_len),
    .lsb_sel_i(park_ord),
    .out_o    (rx_parked)
  );

  rx_hold_buf #(.W(DATA_W)) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_direct | unpark),
    .din_i (buf_din),
    .clr_i (rd_ok),
    .dout_o(buf_dout),
    .full_o(full)
  );

  always_ff @(posedge clk_i) begin
    if (wr_ok) tx_q <= wdata_i;
  end

  frame_align #(.W(DATA_W), .KIND(ALIGN_TX)) u_align_tx (
    .raw_i    (tx_q),
    .len_i    (frame_bits_i),
    .lsb_sel_i(lsb_first_i),
    .out_o    (tx_data_o)
  );

  assign rdata_o = en_i ? buf_dout : '0;
  assign full_o  = full;
  assign hold_o  = parked;

endmodule

// File: rtl/i2c_rx_dbuf_chk.sv
module i2c_rx_dbuf_chk #(
  parameter  int DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              xmit_mode_i,
  input logic              frame_done_i,
  input logic              hold_o,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_o
);

  assert_load_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i && !xmit_mode_i && !full_o && !hold_o |=> full_o);

  assert_park_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i && !xmit_mode_i && full_o && !hold_o && !(rd_i && en_i) |=> hold_o && full_o);

  assert_hold_needs_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> full_o);

  assert_unpark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && en_i && hold_o && !xmit_mode_i |=> full_o && !hold_o);

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && en_i && !hold_o && !(frame_done_i && !xmit_mode_i) |=> !full_o);

  assert_tx_no_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_mode_i |=> !hold_o);

  assert_tx_no_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_mode_i && !full_o |=> !full_o);

  assert_dis_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> rdata_o == '0);

  assert_dis_keep_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && full_o |=> full_o);

  assert_collide_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && en_i && full_o && !hold_o && frame_done_i && !xmit_mode_i |=> full_o && !hold_o);

endmodule

bind i2c_rx_dbuf i2c_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .xmit_mode_i (xmit_mode_i),
  .frame_done_i(frame_done_i),
  .hold_o      (hold_o),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .full_o      (full_o)
);

// File: tb/i2c_rx_dbuf_tb.sv
`timescale 1ns/1ps
module i2c_rx_dbuf_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       xmit_mode_i = 1'b0;
  logic       lsb_first_i = 1'b0;
  logic [2:0] frame_bits_i = 3'd0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       frame_done_i = 1'b0;
  logic       hold_o;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       full_o;
  logic [7:0] tx_data_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  i2c_rx_dbuf u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .xmit_mode_i(xmit_mode_i),
    .lsb_first_i(lsb_first_i), .frame_bits_i(frame_bits_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .frame_done_i(frame_done_i),
    .hold_o(hold_o), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .full_o(full_o), .tx_data_o(tx_data_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_exp(input logic [7:0] pat, input int n, input bit ord);
    logic [7:0] m;
    m = pat & 8'((1 << n) - 1);
    return ord ? 8'(m << (8 - n)) : m;
  endfunction

  // monitor: compare every enabled read against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rd_i && en_i) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected read actual=%0h expected=none", rdata_o);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rdata_o, e);
      end
    end
  end

  task automatic send_frame(input logic [7:0] pat, input int n, input bit ord,
                            input bit rd_at_done, input logic [7:0] rd_exp, input string tag);
    @(posedge clk_i); #1;
    frame_bits_i = 3'(n);
    lsb_first_i  = ord;
    for (int i = 0; i < n; i++) begin
      bit_valid_i = 1'b1;
      bit_i = pat[n-1-i];
      @(posedge clk_i); #1;
    end
    bit_valid_i = 1'b0;
    if (rd_at_done) begin
      exp_q.push_back(rd_exp); tag_q.push_back(tag);
      rd_i = 1'b1;
    end
    frame_done_i = 1'b1;
    @(posedge clk_i); #1;
    frame_done_i = 1'b0;
    rd_i = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk_i); #1; rd_i = 1'b1;
    @(posedge clk_i); #1; rd_i = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(posedge clk_i); #1; wr_i = 1'b1; wdata_i = d;
    @(posedge clk_i); #1; wr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 full after reset", 8'(full_o), 8'd0);
    chk("R1 hold after reset", 8'(hold_o), 8'd0);
    chk("R9 rdata disabled", rdata_o, 8'h00);
    en_i = 1'b1;

    // full byte, length code 0
    send_frame(8'hA5, 8, 1'b0, 1'b0, 8'h00, "");
    @(negedge clk_i);
    chk("R2 full after frame", 8'(full_o), 8'd1);
    cpu_read(8'hA5, "R10 eight-bit frame data");
    @(negedge clk_i);
    chk("R5 read clears full", 8'(full_o), 8'd0);

    // short frames over stale shift contents
    send_frame(8'b000_10110, 5, 1'b0, 1'b0, 8'h00, "");
    cpu_read(rx_exp(8'b10110, 5, 1'b0), "R7 short frame lsb end");
    send_frame(8'b0000_0101, 3, 1'b1, 1'b0, 8'h00, "");
    cpu_read(rx_exp(8'b101, 3, 1'b1), "R7 short frame msb end");

    // double buffering
    send_frame(8'h11, 8, 1'b0, 1'b0, 8'h00, "");
    send_frame(8'h22, 8, 1'b0, 1'b0, 8'h00, "");
    @(negedge clk_i);
    chk("R3 hold set", 8'(hold_o), 8'd1);
    chk("R3 buffer unchanged", rdata_o, 8'h11);
    send_frame(8'hFF, 8, 1'b0, 1'b0, 8'h00, "");
    @(negedge clk_i);
    chk("R12 hold kept", 8'(hold_o), 8'd1);
    cpu_read(8'h11, "R4 first byte");
    @(negedge clk_i);
    chk("R4 full stays", 8'(full_o), 8'd1);
    chk("R4 hold drops", 8'(hold_o), 8'd0);
    cpu_read(8'h22, "R12 parked frame intact");
    @(negedge clk_i);
    chk("R5 empty again", 8'(full_o), 8'd0);

    // disabled access
    send_frame(8'h33, 8, 1'b0, 1'b0, 8'h00, "");
    @(posedge clk_i); #1; en_i = 1'b0; rd_i = 1'b1;
    @(negedge clk_i);
    chk("R9 rdata zero", rdata_o, 8'h00);
    @(posedge clk_i); #1; rd_i = 1'b0; en_i = 1'b1;
    @(negedge clk_i);
    chk("R9 full kept", 8'(full_o), 8'd1);
    cpu_read(8'h33, "R9 data kept");

    // transmit mode
    @(posedge clk_i); #1; xmit_mode_i = 1'b1; frame_done_i = 1'b1;
    @(posedge clk_i); #1; frame_done_i = 1'b0;
    @(negedge clk_i);
    chk("R6 no fill in tx", 8'(full_o), 8'd0);
    @(posedge clk_i); #1; xmit_mode_i = 1'b0;
    send_frame(8'h44, 8, 1'b0, 1'b0, 8'h00, "");
    send_frame(8'h55, 8, 1'b0, 1'b0, 8'h00, "");
    @(posedge clk_i); #1; xmit_mode_i = 1'b1;
    @(posedge clk_i); #1; xmit_mode_i = 1'b0;
    @(negedge clk_i);
    chk("R6 hold cleared", 8'(hold_o), 8'd0);
    cpu_read(8'h44, "R6 buffered byte");
    @(negedge clk_i);
    chk("R6 parked discarded", 8'(full_o), 8'd0);

    // read colliding with frame completion
    send_frame(8'h66, 8, 1'b0, 1'b0, 8'h00, "");
    send_frame(8'h77, 8, 1'b0, 1'b1, 8'h66, "R11 old byte");
    @(negedge clk_i);
    chk("R11 full stays", 8'(full_o), 8'd1);
    chk("R11 no hold", 8'(hold_o), 8'd0);
    cpu_read(8'h77, "R11 new byte");

    // transmit alignment
    frame_bits_i = 3'd0; lsb_first_i = 1'b0;
    cpu_write(8'hC3);
    @(negedge clk_i);
    chk("R8 tx eight bits", tx_data_o, 8'hC3);
    frame_bits_i = 3'd4;
    @(negedge clk_i);
    chk("R8 tx msb source", tx_data_o, 8'hC0);
    lsb_first_i = 1'b1;
    @(negedge clk_i);
    chk("R8 tx lsb source", tx_data_o, 8'h30);
    en_i = 1'b0;
    cpu_write(8'hFF);
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R9 write ignored", tx_data_o, 8'h30);

    repeat (2) @(posedge clk_i);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule